// File: doc/BRIEF.md
# Load-Use and Branch Stall Controller

This block decides, from the decode stage of a five-stage in-order pipeline, when the front end must freeze and when a bubble must enter the execute stage. It compares the source registers read by the instruction in decode with the destination of the instruction in execute. If that producer is a load, a plain consumer waits one cycle, and forwarding covers the rest of the gap. A branch that compares its operands in decode needs its operands earlier. It waits one cycle behind an ALU producer and a fixed run of cycles (two by default) behind a load. During a stall the program-counter write enable and the fetch/decode register write enable are dropped, and a control-zero signal clears every control line entering the decode/execute register.

Branches are predicted not taken. When a decode-stage branch resolves taken and the unit is not stalling, it raises a flush of the fetch/decode register, so the wrongly fetched instruction becomes a NOP. The load-to-branch run is held by a small down-counter. The extra stall cycles therefore come from that counter and not from the register fields present in those cycles.

Top module: `hz_stall_unit`

## Requirements
- R1: After reset is applied, or when it is asserted while extra stall cycles are pending, nothing is pending: with no hazard on the inputs, pc_write_o=1, ifid_write_o=1, ctrl_zero_o=0 and if_flush_o=0.
- R2: If ex_reg_write_i=1, ex_mem_read_i=1 and a used, nonzero source of a non-branch decode instruction equals ex_dst_i, the unit stalls for that cycle: pc_write_o=0, ifid_write_o=0, ctrl_zero_o=1, if_flush_o=0.
- R3: A source only takes part in the comparison when its used flag is 1 and its index is nonzero. A source that is unused or names register 0 never causes a stall.
- R4: If the producer in execute is an ALU instruction (ex_reg_write_i=1, ex_mem_read_i=0), a non-branch consumer does not stall.
- R5: A branch in decode (id_branch_i=1) that depends on an ALU producer in execute stalls for exactly that cycle.
- R6: A branch in decode that depends on a load in execute stalls in that cycle and then in the next LOAD_BR_STALLS-1 cycles whatever the inputs are. After that it is released. The default is 2 stall cycles in total.
- R7: A branch is taken when id_cmp_eq_i=1 for id_branch_ne_i=0, and when id_cmp_eq_i=0 for id_branch_ne_i=1. A taken branch in a cycle without a stall gives if_flush_o=1 with pc_write_o=1 and ifid_write_o=1.
- R8: if_flush_o is never 1 in a cycle in which ctrl_zero_o is 1.
- R9: If ex_reg_write_i=0, the execute instruction is never treated as a producer, whatever ex_mem_read_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs_i | input | REG_W | First source register index of the decode instruction |
| id_rt_i | input | REG_W | Second source register index of the decode instruction |
| id_rs_used_i | input | 1 | The decode instruction reads its first source |
| id_rt_used_i | input | 1 | The decode instruction reads its second source |
| id_branch_i | input | 1 | The decode instruction is a conditional branch compared in decode |
| id_branch_ne_i | input | 1 | Branch kind: 1 = taken on inequality, 0 = taken on equality |
| id_cmp_eq_i | input | 1 | Equality result of the decode-stage comparator |
| ex_mem_read_i | input | 1 | The execute instruction reads memory (load) |
| ex_reg_write_i | input | 1 | The execute instruction writes a register |
| ex_dst_i | input | REG_W | Destination register index of the execute instruction |
| pc_write_o | output | 1 | Program counter update enable |
| ifid_write_o | output | 1 | Fetch/decode register write enable |
| ctrl_zero_o | output | 1 | Clear all control lines entering decode/execute (bubble) |
| if_flush_o | output | 1 | Clear the fetch/decode register to a NOP |

## Verification
The hardest case to reach from the ports is the second stall cycle behind a load that feeds a branch. In that cycle the inputs no longer show the hazard, and the outcome depends only on state held from the cycle before. The bench sweeps every combination of four register indices, the used flags, the producer kind, the branch kind and the comparator result. Each vector that arms the load-to-branch run is followed by extra cycles whose inputs show a taken branch with no dependency. A correct unit stalls and suppresses the flush in those cycles and then flushes once it is released. One armed run is cut short by an asynchronous reset to show that the pending stall is dropped.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    PROD_NONE = 2'd0,
    PROD_ALU  = 2'd1,
    PROD_LOAD = 2'd2
  } prod_kind_e;

  function automatic prod_kind_e classify_prod(input logic reg_write, input logic mem_read);
    if (!reg_write)    return PROD_NONE;
    else if (mem_read) return PROD_LOAD;
    else               return PROD_ALU;
  endfunction

  function automatic logic branch_taken(input logic is_ne, input logic cmp_eq);
    return is_ne ? !cmp_eq : cmp_eq;
  endfunction
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] src_i,
  input  logic [NSRC-1:0]            used_i,
  input  logic [REG_W-1:0]           dst_i,
  output logic                       hit_o
);
  logic [NSRC-1:0] hit_vec;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // register 0 is hard-wired, never a dependency
    assign hit_vec[g] = used_i[g] && (src_i[g] != '0) && (src_i[g] == dst_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/hz_stall_seq.sv
module hz_stall_seq #(
  parameter int EXTRA = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic hold_o
);
  if (EXTRA > 0) begin : g_cnt
    localparam int CNT_W = $clog2(EXTRA + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      else if (arm_i)        cnt_q <= CNT_W'(EXTRA);
    end

    assign hold_o = (cnt_q != '0);
  end else begin : g_none
    assign hold_o = 1'b0;
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_W          = 5,
  parameter int LOAD_BR_STALLS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_rs_used_i,
  input  logic             id_rt_used_i,
  input  logic             id_branch_i,
  input  logic             id_branch_ne_i,
  input  logic             id_cmp_eq_i,
  input  logic             ex_mem_read_i,
  input  logic             ex_reg_write_i,
  input  logic [REG_W-1:0] ex_dst_i,
  output logic             pc_write_o,
  output logic             ifid_write_o,
  output logic             ctrl_zero_o,
  output logic             if_flush_o
);
  localparam int EXTRA = (LOAD_BR_STALLS > 1) ? LOAD_BR_STALLS - 1 : 0;

  prod_kind_e prod;
  logic       dep, hold_w, ld_use, alu_br, ld_br, stall;

  assign prod = classify_prod(ex_reg_write_i, ex_mem_read_i);

  hz_src_match #(.REG_W(REG_W), .NSRC(2)) u_match (
    .src_i  ({id_rt_i, id_rs_i}),
    .used_i ({id_rt_used_i, id_rs_used_i}),
    .dst_i  (ex_dst_i),
    .hit_o  (dep)
  );

  assign ld_use = dep && (prod == PROD_LOAD);
  assign alu_br = dep && id_branch_i && (prod == PROD_ALU);
  assign ld_br  = ld_use && id_branch_i;

  // fields seen while holding are stale; the counter alone drives those cycles
  hz_stall_seq #(.EXTRA(EXTRA)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (ld_br && !hold_w),
    .hold_o (hold_w)
  );

  assign stall        = hold_w || ld_use || alu_br;
  assign pc_write_o   = !stall;
  assign ifid_write_o = !stall;
  assign ctrl_zero_o  = stall;
  assign if_flush_o   = !stall && id_branch_i && branch_taken(id_branch_ne_i, id_cmp_eq_i);
endmodule

// File: rtl/hz_stall_unit_chk.sv
module hz_stall_unit_chk #(
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] id_rs_i,
  input logic [REG_W-1:0] id_rt_i,
  input logic             id_rs_used_i,
  input logic             id_rt_used_i,
  input logic             id_branch_i,
  input logic             id_branch_ne_i,
  input logic             id_cmp_eq_i,
  input logic             ex_mem_read_i,
  input logic             ex_reg_write_i,
  input logic [REG_W-1:0] ex_dst_i,
  input logic             pc_write_o,
  input logic             ifid_write_o,
  input logic             ctrl_zero_o,
  input logic             if_flush_o,
  input logic             hold_w
);
  logic m_rs, m_rt, dep, live_rs, live_rt;
  assign m_rs    = id_rs_used_i && (id_rs_i != '0) && (id_rs_i == ex_dst_i);
  assign m_rt    = id_rt_used_i && (id_rt_i != '0) && (id_rt_i == ex_dst_i);
  assign dep     = m_rs || m_rt;
  assign live_rs = id_rs_used_i && (id_rs_i != '0);
  assign live_rt = id_rt_used_i && (id_rt_i != '0);

  assert_load_use_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_reg_write_i && ex_mem_read_i && dep) |-> (ctrl_zero_o && !pc_write_o && !ifid_write_o));

  assert_zero_src_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!live_rs && !live_rt && !hold_w) |-> !ctrl_zero_o);

  assert_alu_no_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_reg_write_i && !ex_mem_read_i && !id_branch_i && !hold_w) |-> pc_write_o);

  assert_alu_branch_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_branch_i && ex_reg_write_i && !ex_mem_read_i && dep) |-> ctrl_zero_o);

  assert_load_branch_second_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_branch_i && ex_reg_write_i && ex_mem_read_i && dep && !hold_w) |=> ctrl_zero_o);

  assert_taken_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_branch_i && !ctrl_zero_o && (id_branch_ne_i != id_cmp_eq_i)) |-> (if_flush_o && pc_write_o));

  assert_no_flush_in_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_zero_o |-> !if_flush_o);

  assert_no_producer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_reg_write_i && !hold_w) |-> !ctrl_zero_o);
endmodule

bind hz_stall_unit hz_stall_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .id_rs_i        (id_rs_i),
  .id_rt_i        (id_rt_i),
  .id_rs_used_i   (id_rs_used_i),
  .id_rt_used_i   (id_rt_used_i),
  .id_branch_i    (id_branch_i),
  .id_branch_ne_i (id_branch_ne_i),
  .id_cmp_eq_i    (id_cmp_eq_i),
  .ex_mem_read_i  (ex_mem_read_i),
  .ex_reg_write_i (ex_reg_write_i),
  .ex_dst_i       (ex_dst_i),
  .pc_write_o     (pc_write_o),
  .ifid_write_o   (ifid_write_o),
  .ctrl_zero_o    (ctrl_zero_o),
  .if_flush_o     (if_flush_o),
  .hold_w         (hold_w)
);

// File: tb/sim_hz_stall_unit.sv
module sim_hz_stall_unit;
  localparam int CLK_P = 10;
  localparam int REG_W = 5;
  localparam int LBS   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [REG_W-1:0] rs, rt, dst;
  logic ur, ut, br, ne, eq, mr, rw;
  logic pc_w, ifid_w, cz, fl;
  int total = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  hz_stall_unit #(.REG_W(REG_W), .LOAD_BR_STALLS(LBS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs_i(rs), .id_rt_i(rt), .id_rs_used_i(ur), .id_rt_used_i(ut),
    .id_branch_i(br), .id_branch_ne_i(ne), .id_cmp_eq_i(eq),
    .ex_mem_read_i(mr), .ex_reg_write_i(rw), .ex_dst_i(dst),
    .pc_write_o(pc_w), .ifid_write_o(ifid_w), .ctrl_zero_o(cz), .if_flush_o(fl)
  );

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {pc_w, ifid_w, cz, fl};
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual={pc,ifid,zero,flush}=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic neutral();
    rs = '0; rt = '0; dst = '0; ur = 0; ut = 0;
    br = 0; ne = 0; eq = 0; mr = 0; rw = 0;
  endtask

  // taken branch with no dependency: would flush unless held
  task automatic taken_nodep();
    neutral(); br = 1; eq = 1; rs = 5'd1; ur = 1; dst = 5'd2; rw = 1; mr = 1;
  endtask

  task automatic ldbr_vec();
    neutral(); br = 1; rs = 5'd3; ur = 1; dst = 5'd3; rw = 1; mr = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    neutral();
    #1 chk("R1 in reset", 4'b1100);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1 chk("R1 after reset", 4'b1100);

    // exhaustive sweep over 4 register indices and every flag
    for (int v = 0; v < 8192; v++) begin
      logic [12:0] b;
      logic dep, raw, load, alu, stall, taken, ldbr;
      string tag;
      b = 13'(v);
      @(negedge clk);
      rs = REG_W'(b[1:0]); rt = REG_W'(b[3:2]); dst = REG_W'(b[5:4]);
      ur = b[6]; ut = b[7]; mr = b[8]; rw = b[9]; br = b[10]; ne = b[11]; eq = b[12];
      raw   = (rs == dst) || (rt == dst);
      dep   = (ur && rs != 0 && rs == dst) || (ut && rt != 0 && rt == dst);
      load  = rw && mr;
      alu   = rw && !mr;
      stall = dep && (load || (br && alu));
      taken = br && (ne ? !eq : eq);
      ldbr  = br && load && dep;
      if (!rw)                 tag = "R9 no producer";
      else if (raw && !dep)    tag = "R3 zero/unused source";
      else if (ldbr)           tag = "R6 load->branch first";
      else if (br && alu && dep) tag = "R5 alu->branch";
      else if (load && dep)    tag = "R2 load-use";
      else if (alu && dep)     tag = "R4 alu no stall";
      else if (taken)          tag = "R7 taken flush";
      else                     tag = "R8 quiet";
      #1 chk(tag, {!stall, !stall, stall, !stall && taken});
      if (ldbr) begin
        for (int k = 1; k < LBS; k++) begin
          @(negedge clk); taken_nodep();
          #1 chk("R6 held stall / R8 no flush", 4'b0010);
        end
        @(negedge clk); taken_nodep();
        #1 chk("R6 release then R7 flush", 4'b1101);
      end
    end

    // reset drops a pending load->branch stall
    @(negedge clk); ldbr_vec();
    #1 chk("R6 arm", 4'b0010);
    @(negedge clk); rst_ni = 1'b0; neutral();
    #1 chk("R1 reset clears pending", 4'b1100);
    @(negedge clk); rst_ni = 1'b1;
    #1 chk("R1 idle after reset", 4'b1100);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule